// File: doc/BRIEF.md
# Synchronous SRAM Port for an AHB-Lite Slave

This block is the path from an AHB-Lite slave slot to an external synchronous SRAM. The external memory window is split into two halves, and a remap input chooses which half belongs to the SRAM. Byte, halfword and word reads and writes are turned into single-cycle device commands. Each command carries active-low chip select, output enable, write enable and four active-low byte-lane enables. The address and write-data buses are shared with other memory on the board, and the write-data driver is enabled only while this block owns the bus.

The device clock is the inverse of the bus clock. Commands are launched on a bus clock rising edge, so the device samples them half a cycle later, in the middle of the command's stable window. A parameter sets where read data is captured, so that it matches a device running in flow-through mode or in pipelined mode. The bus transfer is stretched with HREADY low until that capture has happened.

The sequencer states are IDLE, WR_DATA, WR_CMD, RD_CMD, RD_WAIT and RD_DONE. IDLE, WR_CMD and RD_DONE can accept a transfer. From any of them, an accepted write goes to WR_DATA and an accepted read goes to RD_CMD. When nothing is accepted they go to IDLE. WR_DATA always goes to WR_CMD. RD_CMD goes to RD_DONE in flow-through mode and to RD_WAIT in pipelined mode. RD_WAIT always goes to RD_DONE.

Top module: `sram_sync_ahb`

## Requirements
- R1: `sram_clk` is the logical inverse of `clk` at all times.
- R2: A transfer is taken by the SRAM only when `hsel`, `hready_in` and `htrans[1]` are high and `haddr[27]` differs from `remap`. Any other selected transfer completes with no wait state and leaves `sram_cs_n` high.
- R3: With `FLOW_THRU`=1, a read holds `hready` low for exactly one cycle. With `FLOW_THRU`=0 (the default), it holds `hready` low for exactly two cycles. The returned word is the one the device stored at the address.
- R4: In the cycle after a read's address phase, `sram_cs_n` and `sram_oe_n` are low and `sram_we_n` is high. `hrdata` shows the captured word only in the cycle that ends the transfer and is zero whenever `hready` is low.
- R5: A write's data phase lasts two cycles, with `hready` low in the first. In the second cycle `sram_cs_n` and `sram_we_n` are low, `sram_oe_n` is high, `mem_data_oe` is high, and `mem_wdata` equals the `hwdata` of that transfer.
- R6: `sram_be_n` marks lane i active with a 0. A byte (`hsize`=0) enables lane `haddr[1:0]`. A halfword (`hsize`=1) enables lanes 1:0 when `haddr[1]`=0 and lanes 3:2 when `haddr[1]`=1. A word enables all four lanes. Lane i carries data bits 8i+7:8i, and only enabled lanes are changed by a write.
- R7: With `ADDR_MODE`=2 (the default), `mem_addr` during a command equals `{2'b00, haddr[26:2]}`. So the same offset reaches the same device word whichever half the remap places the SRAM in.
- R8: While `rst_n` is low, `hready` is 1, `hrdata` is 0, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_be_n` is 4'hF and `mem_data_oe` is 0.
- R9: In both read modes, a value written with any size at any naturally aligned offset reads back as the expected word.
- R10: `sram_we_n` and `sram_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| hwrite | input | 1 | 1 = write transfer |
| hready_in | input | 1 | Bus-wide ready |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| haddr | input | 28 | Window byte address |
| hwdata | input | 32 | Write data |
| remap | input | 1 | Swaps the SRAM half of the window |
| hrdata | output | 32 | Read data |
| hready | output | 1 | Transfer completion |
| hresp | output | 2 | Response, always OKAY |
| sram_clk | output | 1 | Device clock, inverse of clk |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 4 | Byte-lane enables, active low |
| mem_addr | output | 27 | Shared memory address |
| mem_wdata | output | 32 | Shared write data |
| mem_data_oe | output | 1 | Drive enable for the shared data bus |
| mem_rdata | input | 32 | Data returned from the device |

## Verification
On every cycle, the assertions check three things: the number of low-`hready` cycles for each read latency, the command pattern that follows an accepted read or write, and the silence of `hrdata` during waits. They also check that write and output enables never overlap, and that a miss of the SRAM half never raises a strobe. The correctness of the data can only be shown by the bench's scenarios. These include lane masking for every size and alignment, the word landing at the mapped device address, and the swap of halves by remap. Both device latencies are modelled in the bench, with behavioural memories next to two instances run side by side.

// File: rtl/sram_sync_pkg.sv
package sram_sync_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_DATA,
        ST_WR_CMD,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_RD_DONE
    } seq_state_t;

    // Active-high lane mask for a transfer; little-endian lane order.
    function automatic logic [LANES-1:0] lane_mask(input logic [2:0] size,
                                                   input logic [1:0] low_addr);
        logic [LANES-1:0] m;
        if (size == 3'd0) begin
            m = 4'b0001 << low_addr;
        end else if (size == 3'd1) begin
            m = low_addr[1] ? 4'b1100 : 4'b0011;
        end else begin
            m = 4'b1111;
        end
        return m;
    endfunction

endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode
    import sram_sync_pkg::*;
#(
    parameter int WIN_AW    = 28,
    parameter int ADDR_MODE = 2,
    localparam int MA_W     = WIN_AW - 1
) (
    input  logic [WIN_AW-1:0] haddr,
    input  logic [2:0]        hsize,
    input  logic              remap,
    output logic              hit,
    output logic [MA_W-1:0]   dev_addr,
    output logic [LANES-1:0]  lanes
);

    logic [MA_W-1:0] offset;

    assign offset = haddr[MA_W-1:0];
    // SRAM occupies the upper half unless remap swaps the halves.
    assign hit    = haddr[WIN_AW-1] ^ remap;
    assign lanes  = lane_mask(hsize, haddr[1:0]);

    generate
        if (ADDR_MODE == 0) begin : g_byte_addr
            assign dev_addr = offset;
        end else if (ADDR_MODE == 1) begin : g_half_addr
            assign dev_addr = {1'b0, offset[MA_W-1:1]};
        end else begin : g_word_addr
            assign dev_addr = {2'b00, offset[MA_W-1:2]};
        end
    endgenerate

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_sync_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic ready,
    output logic accept_rd,
    output logic accept_wr,
    output logic issue_wr,
    output logic capture,
    output logic rd_hold_next,
    output logic show_rdata
);

    seq_state_t state_q, state_d;
    logic       accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ready        = 1'b0;
        accept       = 1'b0;
        state_d      = state_q;
        unique case (state_q)
            ST_IDLE, ST_WR_CMD, ST_RD_DONE: begin
                ready  = 1'b1;
                accept = req_valid;
                if (req_valid) begin
                    state_d = req_write ? ST_WR_DATA : ST_RD_CMD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_DATA: state_d = ST_WR_CMD;
            ST_RD_CMD:  state_d = (RD_LAT == 1) ? ST_RD_DONE : ST_RD_WAIT;
            ST_RD_WAIT: state_d = ST_RD_DONE;
            default:    state_d = ST_IDLE;
        endcase
        accept_rd    = accept && !req_write;
        accept_wr    = accept && req_write;
        issue_wr     = (state_q == ST_WR_DATA);
        capture      = ((state_q == ST_RD_CMD) && (RD_LAT == 1)) || (state_q == ST_RD_WAIT);
        rd_hold_next = (state_d == ST_RD_CMD) || (state_d == ST_RD_WAIT);
        show_rdata   = (state_q == ST_RD_DONE);
    end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_sync_pkg::*;
#(
    parameter int MA_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_rd,
    input  logic              accept_wr,
    input  logic              issue_wr,
    input  logic              rd_hold_next,
    input  logic [MA_W-1:0]   req_addr,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] hwdata,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  be_n,
    output logic [MA_W-1:0]   addr,
    output logic [DATA_W-1:0] wdata,
    output logic              data_oe
);

    logic [MA_W-1:0]  wr_addr_q;
    logic [LANES-1:0] wr_lanes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n       <= 1'b1;
            oe_n       <= 1'b1;
            we_n       <= 1'b1;
            be_n       <= '1;
            addr       <= '0;
            wdata      <= '0;
            data_oe    <= 1'b0;
            wr_addr_q  <= '0;
            wr_lanes_q <= '0;
        end else begin
            if (accept_wr) begin
                wr_addr_q  <= req_addr;
                wr_lanes_q <= req_lanes;
            end
            if (accept_rd) begin
                cs_n    <= 1'b0;
                we_n    <= 1'b1;
                be_n    <= ~req_lanes;
                addr    <= req_addr;
                data_oe <= 1'b0;
            end else if (issue_wr) begin
                cs_n    <= 1'b0;
                we_n    <= 1'b0;
                be_n    <= ~wr_lanes_q;
                addr    <= wr_addr_q;
                wdata   <= hwdata;
                data_oe <= 1'b1;
            end else begin
                cs_n    <= 1'b1;
                we_n    <= 1'b1;
                be_n    <= '1;
                data_oe <= 1'b0;
            end
            oe_n <= !rd_hold_next;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
    import sram_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              show,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] hrdata
);

    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= mem_rdata;
        end
    end

    assign hrdata = show ? word_q : '0;

endmodule

// File: rtl/sram_sync_ahb.sv
module sram_sync_ahb
    import sram_sync_pkg::*;
#(
    parameter int WIN_AW    = 28,
    parameter bit FLOW_THRU = 1'b0,
    parameter int ADDR_MODE = 2,
    localparam int MA_W     = WIN_AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hwrite,
    input  logic              hready_in,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic [WIN_AW-1:0] haddr,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              remap,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic [1:0]        hresp,
    output logic              sram_clk,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [MA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_data_oe,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int RD_LAT = FLOW_THRU ? 1 : 2;

    logic             hit;
    logic [MA_W-1:0]  req_addr;
    logic [LANES-1:0] req_lanes;
    logic             req_valid;
    logic             accept_rd, accept_wr, issue_wr;
    logic             capture, rd_hold_next, show_rdata;

    assign sram_clk  = ~clk;
    assign hresp     = 2'b00;
    assign req_valid = hsel && hready_in && (htrans inside {2'b10, 2'b11}) && hit;

    sram_addr_decode #(
        .WIN_AW   (WIN_AW),
        .ADDR_MODE(ADDR_MODE)
    ) u_decode (
        .haddr   (haddr),
        .hsize   (hsize),
        .remap   (remap),
        .hit     (hit),
        .dev_addr(req_addr),
        .lanes   (req_lanes)
    );

    sram_seq_fsm #(
        .RD_LAT(RD_LAT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (hwrite),
        .ready       (hready),
        .accept_rd   (accept_rd),
        .accept_wr   (accept_wr),
        .issue_wr    (issue_wr),
        .capture     (capture),
        .rd_hold_next(rd_hold_next),
        .show_rdata  (show_rdata)
    );

    sram_pin_drive #(
        .MA_W(MA_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_rd   (accept_rd),
        .accept_wr   (accept_wr),
        .issue_wr    (issue_wr),
        .rd_hold_next(rd_hold_next),
        .req_addr    (req_addr),
        .req_lanes   (req_lanes),
        .hwdata      (hwdata),
        .cs_n        (sram_cs_n),
        .oe_n        (sram_oe_n),
        .we_n        (sram_we_n),
        .be_n        (sram_be_n),
        .addr        (mem_addr),
        .wdata       (mem_wdata),
        .data_oe     (mem_data_oe)
    );

    sram_rd_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .show     (show_rdata),
        .mem_rdata(mem_rdata),
        .hrdata   (hrdata)
    );

endmodule

// File: rtl/sram_sync_ahb_chk.sv
module sram_sync_ahb_chk #(
    parameter int WIN_AW    = 28,
    parameter bit FLOW_THRU = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic              hwrite,
    input logic              hready_in,
    input logic [1:0]        htrans,
    input logic [WIN_AW-1:0] haddr,
    input logic              remap,
    input logic              hready,
    input logic [31:0]       hrdata,
    input logic              sram_cs_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [3:0]        sram_be_n,
    input logic              mem_data_oe
);

    logic taken, in_half, rd_acc, wr_acc, miss_acc;

    assign taken    = hsel && hready_in && hready && (htrans inside {2'b10, 2'b11});
    assign in_half  = haddr[WIN_AW-1] != remap;
    assign rd_acc   = taken && in_half && !hwrite;
    assign wr_acc   = taken && in_half && hwrite;
    assign miss_acc = taken && !in_half;

    generate
        if (FLOW_THRU) begin : g_ft
            a_r3_read_latency_ft: assert property (@(posedge clk) disable iff (!rst_n)
                rd_acc |=> !hready ##1 hready);
        end else begin : g_pipe
            a_r3_read_latency_pipe: assert property (@(posedge clk) disable iff (!rst_n)
                rd_acc |=> !hready ##1 !hready ##1 hready);
        end
    endgenerate

    a_r2_miss_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        miss_acc |=> (sram_cs_n && hready));

    a_r4_read_command: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> (!sram_cs_n && !sram_oe_n && sram_we_n));

    a_r4_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |-> (hrdata == 32'h0));

    a_r5_write_command: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !hready ##1 (hready && !sram_cs_n && !sram_we_n && mem_data_oe));

    a_r6_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && (sram_be_n != 4'hF)));

    a_r10_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

endmodule

bind sram_sync_ahb sram_sync_ahb_chk #(
    .WIN_AW   (WIN_AW),
    .FLOW_THRU(FLOW_THRU)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsel       (hsel),
    .hwrite     (hwrite),
    .hready_in  (hready_in),
    .htrans     (htrans),
    .haddr      (haddr),
    .remap      (remap),
    .hready     (hready),
    .hrdata     (hrdata),
    .sram_cs_n  (sram_cs_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_be_n  (sram_be_n),
    .mem_data_oe(mem_data_oe)
);

// File: tb/sram_sync_ahb_tb.sv
module sram_dev_model #(
    parameter bit FLOW_THRU = 1'b0
) (
    input  logic        sram_clk,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [3:0]  be_n,
    input  logic [26:0] addr,
    input  logic [31:0] wdata,
    input  logic        data_oe,
    output logic [31:0] rdata
);
    logic [31:0] mem [int];
    logic [31:0] q1, q2;

    always @(posedge sram_clk) begin
        logic [31:0] cur;
        cur = mem.exists(int'(addr)) ? mem[int'(addr)] : 32'hDEAD_BEEF;
        if (!cs_n && !we_n && data_oe) begin
            for (int i = 0; i < 4; i++)
                if (!be_n[i]) cur[8*i +: 8] = wdata[8*i +: 8];
            mem[int'(addr)] = cur;
            q1 <= 'x;
        end else if (!cs_n) begin
            q1 <= cur;
        end else begin
            q1 <= 'x;
        end
        q2 <= q1;
    end

    assign rdata = oe_n ? 'x : (FLOW_THRU ? q1 : q2);
endmodule

module sram_sync_ahb_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        hsel = 0, hwrite = 0, remap = 0;
    logic [1:0]  htrans = 0;
    logic [2:0]  hsize = 0;
    logic [27:0] haddr = 0;
    logic [31:0] hwdata = 0;

    logic        hready_w   [2];
    logic [31:0] hrdata_w   [2];
    logic [1:0]  hresp_w    [2];
    logic        sclk_w     [2];
    logic        cs_n_w     [2];
    logic        oe_n_w     [2];
    logic        we_n_w     [2];
    logic [3:0]  be_n_w     [2];
    logic [26:0] maddr_w    [2];
    logic [31:0] mwdata_w   [2];
    logic        moe_w      [2];
    logic [31:0] mrdata_w   [2];

    int checks = 0;
    int bad = 0;
    bit running = 1'b1;

    logic [31:0] last_rd  [2];
    int          last_cyc [2];
    logic [31:0] shadow [int];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    for (genvar m = 0; m < 2; m++) begin : g_mode
        sram_sync_ahb #(.FLOW_THRU(m)) u_dut (
            .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwrite(hwrite),
            .hready_in(hready_w[m]), .htrans(htrans), .hsize(hsize),
            .haddr(haddr), .hwdata(hwdata), .remap(remap),
            .hrdata(hrdata_w[m]), .hready(hready_w[m]), .hresp(hresp_w[m]),
            .sram_clk(sclk_w[m]), .sram_cs_n(cs_n_w[m]), .sram_oe_n(oe_n_w[m]),
            .sram_we_n(we_n_w[m]), .sram_be_n(be_n_w[m]), .mem_addr(maddr_w[m]),
            .mem_wdata(mwdata_w[m]), .mem_data_oe(moe_w[m]), .mem_rdata(mrdata_w[m])
        );

        sram_dev_model #(.FLOW_THRU(m)) u_mem (
            .sram_clk(sclk_w[m]), .cs_n(cs_n_w[m]), .oe_n(oe_n_w[m]),
            .we_n(we_n_w[m]), .be_n(be_n_w[m]), .addr(maddr_w[m]),
            .wdata(mwdata_w[m]), .data_oe(moe_w[m]), .rdata(mrdata_w[m])
        );

        // Behavioural per-cycle reference: wait count and expected strobe.
        int left = 0;
        bit wr_pend = 0;
        bit exp_cs_low = 0;
        always @(posedge clk or negedge rst_n) begin
            bit acc;
            if (!rst_n) begin
                left = 0; wr_pend = 0; exp_cs_low = 0;
            end else begin
                acc = (left == 0) && hsel && htrans[1] && (haddr[27] != remap);
                exp_cs_low = (acc && !hwrite) || wr_pend;
                wr_pend = acc && hwrite;
                if (left > 0) left--;
                else if (acc) left = hwrite ? 1 : ((m == 1) ? 1 : 2);
            end
        end

        always @(negedge clk) begin
            if (rst_n && running) begin
                chk(hready_w[m] == (left == 0), "R3", "per-cycle hready",
                    32'(hready_w[m]), 32'(left == 0));
                chk(cs_n_w[m] == !exp_cs_low, "R2", "per-cycle cs_n",
                    32'(cs_n_w[m]), 32'(!exp_cs_low));
                chk(sclk_w[m] === 1'b1, "R1", "sram_clk low phase",
                    32'(sclk_w[m]), 32'd1);
                chk(!(!we_n_w[m] && !oe_n_w[m]), "R10", "we/oe overlap",
                    {we_n_w[m], oe_n_w[m]}, 32'd2);
            end
        end
    end

    function automatic logic [3:0] exp_lanes(input logic [2:0] sz, input logic [1:0] a);
        int cnt;
        int base;
        logic [3:0] r;
        cnt  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        base = int'(a) - (int'(a) % cnt);
        r = 4'b0000;
        for (int i = 0; i < 4; i++)
            if (i >= base && i < base + cnt) r[i] = 1'b1;
        return r;
    endfunction

    task automatic xfer(input bit wr, input logic [27:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
        bit hit;
        bit done [2];
        int n;
        int exp_cyc;
        logic [3:0] ln;
        hit = (a[27] != remap);
        ln = exp_lanes(sz, a[1:0]);
        @(negedge clk);
        hsel = 1; htrans = 2'b10; hwrite = wr; haddr = a; hsize = sz;
        @(negedge clk);
        hsel = 0; htrans = 2'b00;
        if (wr) hwdata = wd;
        done[0] = 0; done[1] = 0; n = 1;
        for (int guard = 0; guard < 8; guard++) begin
            for (int m = 0; m < 2; m++) begin
                if (!done[m]) begin
                    if (hit && !wr && n == 1) begin
                        chk(!cs_n_w[m] && !oe_n_w[m] && we_n_w[m], "R4", "read strobes",
                            {cs_n_w[m], oe_n_w[m], we_n_w[m]}, 32'b001);
                        chk(hrdata_w[m] == 0, "R4", "hrdata quiet in wait", hrdata_w[m], 0);
                        chk(be_n_w[m] == ~ln, "R6", "read lanes", 32'(be_n_w[m]), 32'(~ln));
                        chk(maddr_w[m] == {2'b00, a[26:2]}, "R7", "read address",
                            32'(maddr_w[m]), 32'({2'b00, a[26:2]}));
                    end
                    if (hit && wr && n == 2) begin
                        chk(!cs_n_w[m] && !we_n_w[m] && oe_n_w[m] && moe_w[m], "R5",
                            "write strobes", {cs_n_w[m], we_n_w[m], oe_n_w[m], moe_w[m]}, 32'b0011);
                        chk(mwdata_w[m] == wd, "R5", "write data", mwdata_w[m], wd);
                        chk(be_n_w[m] == ~ln, "R6", "write lanes", 32'(be_n_w[m]), 32'(~ln));
                        chk(maddr_w[m] == {2'b00, a[26:2]}, "R7", "write address",
                            32'(maddr_w[m]), 32'({2'b00, a[26:2]}));
                    end
                    if (hready_w[m]) begin
                        done[m] = 1; last_rd[m] = hrdata_w[m]; last_cyc[m] = n;
                        chk(hresp_w[m] == 2'b00, "R2", "response OKAY", 32'(hresp_w[m]), 0);
                    end
                end
            end
            if (done[0] && done[1]) break;
            @(negedge clk);
            n++;
        end
        for (int m = 0; m < 2; m++) begin
            exp_cyc = !hit ? 1 : (wr ? 2 : ((m == 1) ? 2 : 3));
            chk(done[m] && last_cyc[m] == exp_cyc, hit ? (wr ? "R5" : "R3") : "R2",
                "data-phase length", 32'(last_cyc[m]), 32'(exp_cyc));
        end
    endtask

    task automatic sram_wr(input logic [27:0] a, input logic [2:0] sz, input logic [31:0] d);
        logic [3:0] ln;
        logic [31:0] w;
        int key;
        xfer(1'b1, a, sz, d);
        if (a[27] != remap) begin
            ln = exp_lanes(sz, a[1:0]);
            key = int'(a[26:2]);
            w = shadow.exists(key) ? shadow[key] : 32'hDEAD_BEEF;
            for (int i = 0; i < 4; i++) if (ln[i]) w[8*i +: 8] = d[8*i +: 8];
            shadow[key] = w;
        end
    endtask

    task automatic sram_rd(input logic [27:0] a, input logic [2:0] sz, input string req);
        logic [31:0] e;
        xfer(1'b0, a, sz, 32'h0);
        e = shadow.exists(int'(a[26:2])) ? shadow[int'(a[26:2])] : 32'hDEAD_BEEF;
        for (int m = 0; m < 2; m++)
            chk(last_rd[m] == e, req, m ? "readback flow-through" : "readback pipelined",
                last_rd[m], e);
    endtask

    initial begin
        #(200000 * 10);
        checks++; bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [27:0] base;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk(hready_w[m] == 1 && hrdata_w[m] == 0, "R8", "reset hready/hrdata",
                {hready_w[m], hrdata_w[m][30:0]}, 32'h8000_0000);
            chk({cs_n_w[m], oe_n_w[m], we_n_w[m], moe_w[m]} == 4'b1110, "R8",
                "reset strobes", {cs_n_w[m], oe_n_w[m], we_n_w[m], moe_w[m]}, 32'b1110);
            chk(be_n_w[m] == 4'hF, "R8", "reset lanes", 32'(be_n_w[m]), 32'hF);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;
        for (int m = 0; m < 2; m++)
            chk(sclk_w[m] === 1'b0, "R1", "sram_clk high phase", 32'(sclk_w[m]), 0);

        // Word writes and reads in the SRAM half with remap clear.
        remap = 0;
        base = 28'h800_0000;
        sram_wr(base + 28'h40, 3'd2, 32'hA5A5_0F0F);
        sram_wr(base + 28'h44, 3'd2, 32'h1234_5678);
        sram_rd(base + 28'h40, 3'd2, "R3");
        sram_rd(base + 28'h44, 3'd2, "R3");

        // Every size and aligned offset, both read modes.
        for (int sz = 0; sz < 3; sz++) begin
            for (int al = 0; al < 4; al += (1 << sz)) begin
                logic [27:0] wa;
                wa = base + 28'h100 + 28'(16 * sz) + 28'(al);
                sram_wr({wa[27:2], 2'b00}, 3'd2, 32'h1122_3344 + 32'(sz * 4 + al));
                d = 32'hEEEE_EEEE;
                for (int i = 0; i < 4; i++)
                    if (exp_lanes(3'(sz), wa[1:0])[i]) d[8*i +: 8] = 8'(8'h90 + sz * 16 + al * 4 + i);
                sram_wr(wa, 3'(sz), d);
                sram_rd(wa, 3'(sz), "R6");
                sram_rd({wa[27:2], 2'b00}, 3'd2, "R9");
            end
        end

        // Transfer to the other half is answered at once and does not touch the SRAM.
        xfer(1'b1, 28'h000_0100, 3'd2, 32'hBAD0_BAD0);
        xfer(1'b0, 28'h000_0104, 3'd2, 32'h0);
        sram_rd(base + 28'h100, 3'd2, "R2");

        // Remap set: SRAM now answers in the lower half at the same offsets.
        remap = 1;
        sram_rd(28'h000_0100, 3'd2, "R7");
        sram_wr(28'h000_0200, 3'd2, 32'hC0DE_F00D);
        xfer(1'b1, 28'h800_0200, 3'd2, 32'h0BAD_0BAD);
        remap = 0;
        sram_rd(base + 28'h200, 3'd2, "R2");

        repeat (4) @(negedge clk);
        running = 1'b0;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule